// File: doc/BRIEF.md
# SMM Region Guard

This block holds the system-management memory controls of a host bridge and turns them into a routing decision for every memory access. Two byte-wide control registers and one 16-bit size word sit behind a small configuration port. On the access side, each physical address comes in with a flag that says whether the processor is in system-management mode (SMM). The block answers in the same cycle. The access goes to DRAM, to the PCI or legacy video path, or into a blackhole that returns all ones and drops writes.

Three address windows are guarded:
- the 128 KiB legacy window at 0xA0000;
- its high alias at 0xFEDA0000, which maps onto the same DRAM bytes;
- a carve-out taken from the top of low memory, whose size comes from the extended control register.

A lock bit freezes the configuration until the next reset.

Top module: `smm_region_guard`

## Requirements
- R1: After reset, the control byte (select 0) reads 0x00 and the extended control byte (select 1) reads 0x00. With a nonzero programmable carve-out size, the size word (select 2) reads 0xFFFF.
- R2: With open (control bit 6) set and high-enable (extended bit 7) clear, the legacy window routes to DRAM (route 0) for every access, with the DRAM address equal to the access address. Non-SMM accesses to the high alias route to PCI (route 1).
- R3: With open and high-enable both set, non-SMM accesses to the legacy window route to PCI. Non-SMM accesses to the high alias route to DRAM, at the address minus 0xFEDA0000 plus 0xA0000.
- R4: With open clear, non-SMM accesses to both the legacy window and the high alias route to PCI.
- R5: With global enable (control bit 3) set, SMM accesses reach DRAM in the legacy window when high-enable is clear, and in the high alias when it is set. The other window follows the non-SMM view. With global enable clear, SMM accesses see the non-SMM view.
- R6: With carve-out enable (extended bit 0) set, size code bits 2:1 select 1 MiB (00), 2 MiB (01), 8 MiB (10) or the programmable size in MiB (11, default 16). With the enable clear, there is no carve-out.
- R7: Inside the carve-out [top − size, top), non-SMM accesses route to the blackhole (route 2) with read data 0xFFFFFFFF. SMM accesses route to DRAM.
- R8: Outside the guarded windows, addresses below the low-memory top (default 0x80000000) route to DRAM and addresses at or above it route to PCI.
- R9: Writing lock (control bit 4) as 1 forces open to 0 in the same write, and lock stays set until reset. While locked, only close (bit 5) of the control byte is writable and the extended control byte is read-only.
- R10: A size-word write that leaves the word equal to 0xFFFF makes it read back the programmable size in MiB. Any other value written reads back unchanged.
- R11: Control bits 2:0 and extended bits 6:3 always read 0, whatever is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select: 0 control, 1 extended control, 2 size word, 3 none |
| cfg_wdata | input | 16 | Write data (low byte for the control registers) |
| cfg_rdata | output | 16 | Read data of the selected register |
| acc_addr | input | ADDR_W | Physical address of the access |
| acc_smm | input | 1 | Access is made in SMM |
| route_o | output | 2 | 0 DRAM, 1 PCI path, 2 blackhole |
| dram_addr_o | output | ADDR_W | DRAM address when routed to DRAM |
| hole_data_o | output | 32 | All ones on a blackhole hit, else zero |

## Verification
The hardest state to reach from the ports is the locked configuration. Lock cannot be cleared, so every check that needs a writable register has to run before it, and the checks that follow lock have to run after it. The stimulus therefore visits all the open, high-enable, global-enable and carve-out code combinations first. It then sets lock in the same write as open, so the forced clear of open is observed. It tries to change every field while locked, and finally applies reset again to show that lock is released.

// File: rtl/smg_pkg.sv
package smg_pkg;
   typedef enum logic [1:0] {
      RT_DRAM = 2'd0,
      RT_PCI  = 2'd1,
      RT_HOLE = 2'd2
   } route_e;

   typedef enum logic [1:0] {
      SEL_CTL   = 2'd0,
      SEL_XCTL  = 2'd1,
      SEL_TSIZE = 2'd2,
      SEL_NONE  = 2'd3
   } cfg_sel_e;

   localparam int CTL_OPEN  = 6;
   localparam int CTL_CLOSE = 5;
   localparam int CTL_LOCK  = 4;
   localparam int CTL_GEN   = 3;
   localparam int XCTL_HEN  = 7;
   localparam int XCTL_TEN  = 0;

   localparam logic [7:0] CTL_MASK_FREE  = 8'h78;
   localparam logic [7:0] CTL_MASK_LOCK  = 8'h20;
   localparam logic [7:0] XCTL_MASK_FREE = 8'h87;
   localparam logic [7:0] XCTL_MASK_LOCK = 8'h00;

   localparam logic [15:0] TSIZE_QUERY = 16'hFFFF;
   localparam int          MIB_SHIFT   = 20;
endpackage

// File: rtl/smg_cfg_regs.sv
module smg_cfg_regs
   import smg_pkg::*;
#(
   parameter int EXT_TSEG_MB = 16
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        we,
   input  logic [1:0]  sel,
   input  logic [15:0] wdata,
   output logic [7:0]  ctl_q,
   output logic [7:0]  xctl_q,
   output logic [15:0] tsize_q
);
   localparam logic [15:0] EXT_MB16 = 16'(EXT_TSEG_MB);

   logic       locked;
   logic [7:0] ctl_mask, xctl_mask, ctl_nxt, xctl_nxt;
   logic [15:0] tsize_nxt;

   assign locked    = ctl_q[CTL_LOCK];
   assign ctl_mask  = locked ? CTL_MASK_LOCK  : CTL_MASK_FREE;
   assign xctl_mask = locked ? XCTL_MASK_LOCK : XCTL_MASK_FREE;

   always_comb begin
      ctl_nxt = (ctl_q & ~ctl_mask) | (wdata[7:0] & ctl_mask);
      if (ctl_nxt[CTL_LOCK]) ctl_nxt[CTL_OPEN] = 1'b0;
      xctl_nxt = (xctl_q & ~xctl_mask) | (wdata[7:0] & xctl_mask);
   end

   generate
      if (EXT_TSEG_MB > 0) begin : g_query
         always_comb begin
            tsize_nxt = wdata;
            if (wdata == TSIZE_QUERY) tsize_nxt = EXT_MB16;
         end
      end else begin : g_plain
         always_comb tsize_nxt = wdata;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctl_q   <= 8'h00;
         xctl_q  <= 8'h00;
         tsize_q <= (EXT_TSEG_MB > 0) ? TSIZE_QUERY : 16'h0000;
      end else if (we) begin
         case (cfg_sel_e'(sel))
            SEL_CTL:   ctl_q   <= ctl_nxt;
            SEL_XCTL:  xctl_q  <= xctl_nxt;
            SEL_TSIZE: tsize_q <= tsize_nxt;
            default:   ;
         endcase
      end
   end
endmodule

// File: rtl/smg_tseg_window.sv
module smg_tseg_window
   import smg_pkg::*;
#(
   parameter int          ADDR_W      = 32,
   parameter logic [63:0] LOW_MEM_TOP = 64'h8000_0000,
   parameter int          EXT_TSEG_MB = 16
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [2:0]        xctl_lo,
   output logic              hit
);
   logic [15:0] size_mb;
   logic [63:0] size_b, base, addr64;

   always_comb begin
      unique case (xctl_lo[2:1])
         2'b00:   size_mb = 16'd1;
         2'b01:   size_mb = 16'd2;
         2'b10:   size_mb = 16'd8;
         default: size_mb = 16'(EXT_TSEG_MB);
      endcase
      if (!xctl_lo[XCTL_TEN]) size_mb = 16'd0;
   end

   assign size_b = 64'(size_mb) << MIB_SHIFT;
   assign base   = LOW_MEM_TOP - size_b;
   assign addr64 = 64'(addr);
   assign hit    = (size_mb != 16'd0) && (addr64 >= base) && (addr64 < LOW_MEM_TOP);
endmodule

// File: rtl/smg_route.sv
module smg_route
   import smg_pkg::*;
#(
   parameter int          ADDR_W        = 32,
   parameter logic [63:0] LOW_MEM_TOP   = 64'h8000_0000,
   parameter logic [63:0] LEGACY_BASE   = 64'h000A_0000,
   parameter logic [63:0] LEGACY_SIZE   = 64'h0002_0000,
   parameter logic [63:0] ALIAS_BASE    = 64'hFEDA_0000,
   parameter bit          HIGH_ALIAS_EN = 1'b1
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              smm,
   input  logic              open,
   input  logic              gen,
   input  logic              hen,
   input  logic              tseg_hit,
   output logic [1:0]        route,
   output logic [ADDR_W-1:0] dram_addr,
   output logic [31:0]       hole_data
);
   logic [63:0] addr64;
   logic        lo_hit, hi_hit, lo_ram, hi_ram;
   route_e      rt;

   assign addr64 = 64'(addr);
   assign lo_hit = (addr64 >= LEGACY_BASE) && (addr64 < LEGACY_BASE + LEGACY_SIZE);

   generate
      if (HIGH_ALIAS_EN) begin : g_alias
         assign hi_hit = (addr64 >= ALIAS_BASE) && (addr64 < ALIAS_BASE + LEGACY_SIZE);
      end else begin : g_no_alias
         assign hi_hit = 1'b0;
      end
   endgenerate

   // SMM view overrides the non-SMM view only where global enable grants it
   assign lo_ram = (smm & gen & ~hen) | (open & ~hen);
   assign hi_ram = (smm & gen &  hen) | (open &  hen);

   always_comb begin
      rt        = RT_PCI;
      dram_addr = addr;
      if (lo_hit) begin
         rt = lo_ram ? RT_DRAM : RT_PCI;
      end else if (hi_hit) begin
         rt        = hi_ram ? RT_DRAM : RT_PCI;
         dram_addr = ADDR_W'(addr64 - ALIAS_BASE + LEGACY_BASE);
      end else if (tseg_hit) begin
         rt = smm ? RT_DRAM : RT_HOLE;
      end else if (addr64 < LOW_MEM_TOP) begin
         rt = RT_DRAM;
      end
   end

   assign route     = rt;
   assign hole_data = (rt == RT_HOLE) ? 32'hFFFF_FFFF : 32'h0000_0000;
endmodule

// File: rtl/smm_region_guard.sv
module smm_region_guard
   import smg_pkg::*;
#(
   parameter int          ADDR_W          = 32,
   parameter logic [63:0] LOW_MEM_TOP     = 64'h8000_0000,
   parameter int          EXT_TSEG_MB     = 16,
   parameter int          EXT_TSEG_MAX_MB = 4095,
   parameter bit          HIGH_ALIAS_EN   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [1:0]        cfg_sel,
   input  logic [15:0]       cfg_wdata,
   output logic [15:0]       cfg_rdata,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic              acc_smm,
   output logic [1:0]        route_o,
   output logic [ADDR_W-1:0] dram_addr_o,
   output logic [31:0]       hole_data_o
);
   localparam logic [63:0] LEGACY_BASE = 64'h000A_0000;
   localparam logic [63:0] LEGACY_SIZE = 64'h0002_0000;
   localparam logic [63:0] ALIAS_BASE  = 64'hFEDA_0000;
   localparam int          FIX_MAX_MB  = 8;
   localparam int          BIG_MB      = (EXT_TSEG_MB > FIX_MAX_MB) ? EXT_TSEG_MB : FIX_MAX_MB;
   localparam logic [63:0] BIG_BYTES   = 64'(BIG_MB) << MIB_SHIFT;

   generate
      if (ADDR_W < 32 || ADDR_W > 48) begin : g_bad_aw
         $error("ADDR_W must lie in 32..48");
      end
      if (EXT_TSEG_MB < 0 || EXT_TSEG_MB > EXT_TSEG_MAX_MB) begin : g_bad_ext
         $error("EXT_TSEG_MB outside 0..EXT_TSEG_MAX_MB");
      end
      if (EXT_TSEG_MAX_MB >= 65535) begin : g_bad_max
         $error("EXT_TSEG_MAX_MB must stay below the query code");
      end
      if (LOW_MEM_TOP < BIG_BYTES || LOW_MEM_TOP > ALIAS_BASE) begin : g_bad_top
         $error("LOW_MEM_TOP cannot hold the largest carve-out");
      end
   endgenerate

   logic [7:0]  ctl_q, xctl_q;
   logic [15:0] tsize_q;
   logic        tseg_hit;

   smg_cfg_regs #(.EXT_TSEG_MB(EXT_TSEG_MB)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (cfg_we),
      .sel     (cfg_sel),
      .wdata   (cfg_wdata),
      .ctl_q   (ctl_q),
      .xctl_q  (xctl_q),
      .tsize_q (tsize_q)
   );

   smg_tseg_window #(
      .ADDR_W      (ADDR_W),
      .LOW_MEM_TOP (LOW_MEM_TOP),
      .EXT_TSEG_MB (EXT_TSEG_MB)
   ) u_tseg (
      .addr    (acc_addr),
      .xctl_lo (xctl_q[2:0]),
      .hit     (tseg_hit)
   );

   smg_route #(
      .ADDR_W        (ADDR_W),
      .LOW_MEM_TOP   (LOW_MEM_TOP),
      .LEGACY_BASE   (LEGACY_BASE),
      .LEGACY_SIZE   (LEGACY_SIZE),
      .ALIAS_BASE    (ALIAS_BASE),
      .HIGH_ALIAS_EN (HIGH_ALIAS_EN)
   ) u_route (
      .addr      (acc_addr),
      .smm       (acc_smm),
      .open      (ctl_q[CTL_OPEN]),
      .gen       (ctl_q[CTL_GEN]),
      .hen       (xctl_q[XCTL_HEN]),
      .tseg_hit  (tseg_hit),
      .route     (route_o),
      .dram_addr (dram_addr_o),
      .hole_data (hole_data_o)
   );

   always_comb begin
      unique case (cfg_sel_e'(cfg_sel))
         SEL_CTL:   cfg_rdata = {8'h00, ctl_q};
         SEL_XCTL:  cfg_rdata = {8'h00, xctl_q};
         SEL_TSIZE: cfg_rdata = tsize_q;
         default:   cfg_rdata = 16'h0000;
      endcase
   end
endmodule

// File: rtl/smg_checker.sv
module smg_checker
   import smg_pkg::*;
#(
   parameter int EXT_TSEG_MB = 16
) (
   input logic        clk,
   input logic        rst_n,
   input logic        cfg_we,
   input logic [1:0]  cfg_sel,
   input logic [15:0] cfg_wdata,
   input logic        acc_smm,
   input logic [1:0]  route_o,
   input logic [31:0] hole_data_o,
   input logic [7:0]  ctl_q,
   input logic [7:0]  xctl_q,
   input logic [15:0] tsize_q
);
   p_lock_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $past(ctl_q[CTL_LOCK]) |-> ctl_q[CTL_LOCK]);

   p_lock_shuts_open_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_q[CTL_LOCK] |-> !ctl_q[CTL_OPEN]);

   p_xctl_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $past(ctl_q[CTL_LOCK]) |-> $stable(xctl_q));

   p_smm_never_hole_r7: assert property (@(posedge clk) disable iff (!rst_n)
      acc_smm |-> (route_o != RT_HOLE));

   p_hole_ones_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (route_o == RT_HOLE) |-> (hole_data_o == 32'hFFFF_FFFF));

   p_no_hole_when_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !xctl_q[XCTL_TEN] |-> (route_o != RT_HOLE));

   p_reserved_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_q[2:0] == 3'b000) && (xctl_q[6:3] == 4'b0000));

   generate
      if (EXT_TSEG_MB > 0) begin : g_q
         p_query_answer_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_we && cfg_sel == SEL_TSIZE && cfg_wdata == TSIZE_QUERY)
               |=> (tsize_q == 16'(EXT_TSEG_MB)));
      end
   endgenerate
endmodule

bind smm_region_guard smg_checker #(.EXT_TSEG_MB(EXT_TSEG_MB)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cfg_we      (cfg_we),
   .cfg_sel     (cfg_sel),
   .cfg_wdata   (cfg_wdata),
   .acc_smm     (acc_smm),
   .route_o     (route_o),
   .hole_data_o (hole_data_o),
   .ctl_q       (ctl_q),
   .xctl_q      (xctl_q),
   .tsize_q     (tsize_q)
);

// File: tb/smm_region_guard_bench.sv
module smm_region_guard_bench;
   localparam int CLK_PERIOD = 10;
   localparam logic [1:0] DR = 2'd0, PC = 2'd1, HO = 2'd2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_sel = 2'd3;
   logic [15:0] cfg_wdata = 16'h0;
   logic [15:0] cfg_rdata;
   logic [31:0] acc_addr = 32'h0;
   logic        acc_smm = 1'b0;
   logic [1:0]  route_o;
   logic [31:0] dram_addr_o;
   logic [31:0] hole_data_o;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   typedef struct {
      bit          is_cfg;
      logic [1:0]  route;
      logic [31:0] daddr;
      logic [15:0] rd;
      string       tag;
   } item_t;
   item_t sb[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   smm_region_guard u_smm_region_guard (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .acc_addr(acc_addr),
      .acc_smm(acc_smm), .route_o(route_o), .dram_addr_o(dram_addr_o),
      .hole_data_o(hole_data_o)
   );

   // monitor: compares one pushed expectation per cycle, after the edge settles
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            total++;
            if (it.is_cfg) begin
               if (cfg_rdata !== it.rd) begin
                  bad++;
                  $display("FAIL %s: rdata=%h expected=%h", it.tag, cfg_rdata, it.rd);
               end
            end else begin
               logic [31:0] exp_hole;
               exp_hole = (it.route == HO) ? 32'hFFFF_FFFF : 32'h0;
               if (route_o !== it.route || hole_data_o !== exp_hole ||
                   (it.route == DR && dram_addr_o !== it.daddr)) begin
                  bad++;
                  $display("FAIL %s: route=%0d daddr=%h hole=%h expected route=%0d daddr=%h hole=%h",
                           it.tag, route_o, dram_addr_o, hole_data_o, it.route, it.daddr, exp_hole);
               end
            end
         end
      end
   end

   task automatic cfg_write(input logic [1:0] sel, input logic [15:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0; cfg_sel = 2'd3;
   endtask

   task automatic chk_rd(input logic [1:0] sel, input logic [15:0] exp, input string tag);
      item_t it;
      @(negedge clk);
      cfg_we = 1'b0; cfg_sel = sel;
      it.is_cfg = 1'b1; it.route = DR; it.daddr = '0; it.rd = exp; it.tag = tag;
      sb.push_back(it);
   endtask

   task automatic chk_acc(input logic [31:0] a, input logic smm, input logic [1:0] rt,
                          input logic [31:0] da, input string tag);
      item_t it;
      @(negedge clk);
      acc_addr = a; acc_smm = smm;
      it.is_cfg = 1'b0; it.route = rt; it.daddr = da; it.rd = '0; it.tag = tag;
      sb.push_back(it);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      do_reset();
      // R1 reset values
      chk_rd(2'd0, 16'h0000, "R1 control reset");
      chk_rd(2'd1, 16'h0000, "R1 extended reset");
      chk_rd(2'd2, 16'hFFFF, "R1 size word query");
      // R8 plain memory
      chk_acc(32'h0000_1000, 1'b0, DR, 32'h0000_1000, "R8 low dram");
      chk_acc(32'h9000_0000, 1'b0, PC, 32'h0, "R8 above top");
      chk_acc(32'h7FFF_FFFC, 1'b0, DR, 32'h7FFF_FFFC, "R8 top word with carve-out off");
      // R4 open clear
      chk_acc(32'h000A_0000, 1'b0, PC, 32'h0, "R4 legacy closed");
      chk_acc(32'hFEDA_0000, 1'b0, PC, 32'h0, "R4 alias hidden");
      // R11 reserved bits
      cfg_write(2'd0, 16'h004F);
      chk_rd(2'd0, 16'h0048, "R11 control reserved");
      cfg_write(2'd1, 16'h00FF);
      chk_rd(2'd1, 16'h0087, "R11 extended reserved");
      // R2 open, high-enable clear
      cfg_write(2'd1, 16'h0000);
      cfg_write(2'd0, 16'h0040);
      chk_acc(32'h000A_1234, 1'b0, DR, 32'h000A_1234, "R2 legacy ram non-smm");
      chk_acc(32'h000B_FFFF, 1'b1, DR, 32'h000B_FFFF, "R2 legacy ram smm");
      chk_acc(32'hFEDA_1234, 1'b0, PC, 32'h0, "R2 alias hidden");
      chk_acc(32'h000C_0000, 1'b0, DR, 32'h000C_0000, "R2 just above legacy");
      // R3 open, high-enable set
      cfg_write(2'd1, 16'h0080);
      chk_acc(32'h000A_1234, 1'b0, PC, 32'h0, "R3 legacy to pci");
      chk_acc(32'hFEDA_1234, 1'b0, DR, 32'h000A_1234, "R3 alias ram");
      chk_acc(32'hFEDB_FFFF, 1'b0, DR, 32'h000B_FFFF, "R3 alias last byte");
      chk_acc(32'hFEDC_0000, 1'b0, PC, 32'h0, "R3 past alias");
      // R5 global enable only
      cfg_write(2'd0, 16'h0008);
      cfg_write(2'd1, 16'h0000);
      chk_acc(32'h000A_0010, 1'b1, DR, 32'h000A_0010, "R5 smm legacy ram");
      chk_acc(32'h000A_0010, 1'b0, PC, 32'h0, "R5 non-smm legacy pci");
      chk_acc(32'hFEDA_0010, 1'b1, PC, 32'h0, "R5 smm alias off");
      cfg_write(2'd1, 16'h0080);
      chk_acc(32'hFEDA_0010, 1'b1, DR, 32'h000A_0010, "R5 smm alias ram");
      chk_acc(32'h000A_0010, 1'b1, PC, 32'h0, "R5 smm legacy pci");
      chk_acc(32'hFEDA_0010, 1'b0, PC, 32'h0, "R5 non-smm alias pci");
      cfg_write(2'd0, 16'h0000);
      chk_acc(32'hFEDA_0010, 1'b1, PC, 32'h0, "R5 gen clear alias");
      cfg_write(2'd1, 16'h0000);
      chk_acc(32'h000A_0010, 1'b1, PC, 32'h0, "R5 gen clear legacy");
      // R6 / R7 carve-out sizes
      cfg_write(2'd1, 16'h0001);
      chk_acc(32'h7FF0_0000, 1'b0, HO, 32'h0, "R7 1MiB base hole");
      chk_acc(32'h7FEF_FFFC, 1'b0, DR, 32'h7FEF_FFFC, "R6 1MiB below base");
      chk_acc(32'h7FFF_FFFF, 1'b1, DR, 32'h7FFF_FFFF, "R7 smm reaches ram");
      chk_acc(32'h8000_0000, 1'b0, PC, 32'h0, "R8 top boundary");
      cfg_write(2'd1, 16'h0003);
      chk_acc(32'h7FE0_0000, 1'b0, HO, 32'h0, "R6 2MiB base");
      chk_acc(32'h7FDF_FFFF, 1'b0, DR, 32'h7FDF_FFFF, "R6 2MiB below");
      cfg_write(2'd1, 16'h0005);
      chk_acc(32'h7F80_0000, 1'b0, HO, 32'h0, "R6 8MiB base");
      chk_acc(32'h7F7F_FFFF, 1'b0, DR, 32'h7F7F_FFFF, "R6 8MiB below");
      cfg_write(2'd1, 16'h0007);
      chk_acc(32'h7F00_0000, 1'b0, HO, 32'h0, "R6 16MiB base");
      chk_acc(32'h7EFF_FFFF, 1'b0, DR, 32'h7EFF_FFFF, "R6 16MiB below");
      chk_acc(32'h7F00_0000, 1'b1, DR, 32'h7F00_0000, "R7 smm in 16MiB");
      cfg_write(2'd1, 16'h0006);
      chk_acc(32'h7F00_0000, 1'b0, DR, 32'h7F00_0000, "R6 enable clear");
      // R10 size word
      cfg_write(2'd2, 16'h0005);
      chk_rd(2'd2, 16'h0005, "R10 plain value");
      cfg_write(2'd2, 16'hFFFF);
      chk_rd(2'd2, 16'h0010, "R10 query answered");
      cfg_write(2'd2, 16'h1234);
      chk_rd(2'd2, 16'h1234, "R10 other value");
      // R9 lock
      cfg_write(2'd1, 16'h0001);
      cfg_write(2'd0, 16'h0058);
      chk_rd(2'd0, 16'h0018, "R9 lock clears open");
      chk_acc(32'h000A_0000, 1'b0, PC, 32'h0, "R9 legacy stays closed");
      cfg_write(2'd1, 16'h0087);
      chk_rd(2'd1, 16'h0001, "R9 extended frozen");
      chk_acc(32'h7FF0_0000, 1'b0, HO, 32'h0, "R9 carve-out unchanged");
      cfg_write(2'd0, 16'h0060);
      chk_rd(2'd0, 16'h0038, "R9 only close writable");
      cfg_write(2'd0, 16'h0000);
      chk_rd(2'd0, 16'h0018, "R9 lock sticky");
      // R1 reset releases lock
      do_reset();
      chk_rd(2'd0, 16'h0000, "R1 lock released");
      chk_rd(2'd1, 16'h0000, "R1 extended cleared");
      chk_rd(2'd2, 16'hFFFF, "R1 query reloaded");
      @(negedge clk);
      @(negedge clk);
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: run did not complete, actual=hung expected=done");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule